// File: doc/BRIEF.md
# Three-Pass Common-Mode Suppressor

This block takes one event of channel samples from a strip readout front end and removes the offset that all channels share. Each raw ADC code has that channel's pedestal subtracted first. The block then makes three passes over the stored values, one channel per clock. Each pass keeps the channels that fall inside a window and averages them into a common-mode estimate. The first window is coarse and lopsided, so that real hits and the undershoot left by large earlier hits are kept out. The second and third windows are narrow and centred on the previous estimate. A fourth sweep counts the signal channels and the channels that only rise above threshold once the correction is applied. The block then decides whether the correction may be trusted, and streams out the corrected event.

The sample input and the corrected output are valid/ready streams. `s_ready` is high only while the block is collecting an event. A sample moves on any clock edge where `s_valid` and `s_ready` are both high. After the last sample of an event is taken, `s_ready` stays low until the corrected event has fully drained. On the output side, a word moves on any edge where `m_valid` and `m_ready` are both high. While `m_ready` is low, `m_valid`, `m_data` and `m_last` stay unchanged. The configuration write port, the debug counters and the `done` pulse are plain signals with no handshake.

Top module: `cms_suppressor`

## Requirements
- R1: After reset, `s_ready` is 1, `m_valid` and `done` are 0, and `cm_value` and all three counters read 0.
- R2: While collecting, the block takes exactly 128 samples and stores value = ADC code minus that channel's pedestal, as a signed number. `s_ready` is 0 from the cycle after the last sample is taken until the output has drained, and `s_ready` and `m_valid` are never both high.
- R3: Configuration writes land on a rising edge with `cfg_we` high. With `cfg_addr[7]`=0, the write targets channel `cfg_addr[6:0]`: `cfg_wdata[7]` is the kill flag and `cfg_wdata[5:0]` is the pedestal. With `cfg_addr[7]`=1, `cfg_addr[2:0]` selects a global setting: 0 is the pass-1 width, 1 the pass-2 width, 2 the pass-3 width, 3 the signal threshold, 4 the minimum used-channel count, 5 the recovered-channel limit, and 6 the bypass flag in bit 0. Reset values are 5, 5, 5, 5, 64, 31 and 0, with every pedestal and kill flag at 0.
- R4: Pass 1 uses every live channel with -w1 < value < 2*w1. Each estimate is floor((selected sum + 64) / 128).
- R5: Passes 2 and 3 use every live channel whose distance from the previous estimate is below w2 or w3 respectively.
- R6: Killed channels never enter a sum or a counter, and their output word is 0.
- R7: `n3_count` is the number of channels used in pass 3. `nsig_count` counts live channels with value > thr. `nrec_count` counts live channels with value <= thr and (value - pass-3 estimate) > thr.
- R8: `cm_value` is forced to 0 when `n3_count` is below the minimum or `nrec_count` is above the limit; otherwise it is the pass-3 estimate.
- R9: With bypass set, `cm_value` is 0, so the output carries the pedestal-subtracted values unchanged.
- R10: Output words come in channel order. Each word is value - `cm_value` as 8-bit two's complement, `m_last` marks channel 127, and the word is held while `m_ready` is low.
- R11: `done` is a one-cycle pulse in the same cycle that the new `cm_value` and counters appear and the first output word becomes valid. `cm_value` is 8-bit two's complement, so its MSB is 1 exactly when the value is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Bit 7 selects global (1) or channel (0) space |
| cfg_wdata | input | 8 | Configuration write data |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block is collecting samples |
| s_adc | input | 6 | Raw ADC code |
| m_valid | output | 1 | Corrected word valid |
| m_ready | input | 1 | Downstream accepts word |
| m_data | output | 8 | Corrected sample, two's complement |
| m_last | output | 1 | Final channel of the event |
| cm_value | output | 8 | Applied common mode, two's complement |
| n3_count | output | 8 | Channels used in pass 3 |
| nsig_count | output | 8 | Channels above signal threshold |
| nrec_count | output | 8 | Channels recovered by the correction |
| done | output | 1 | New result pulse |

## Verification
The bench sweeps a flat offset across both edges of the lopsided first window. A design with a symmetric window, or with `<=` where `<` is required, would report the wrong estimate and the wrong used-channel count at those edges. Negative events check that the rounding floors toward minus infinity; truncating toward zero would give an estimate off by one. Patterns built to recover exactly 40 channels, and to use 88, trip each veto alone, so a design that skips either count or compares with the wrong sense would keep a correction it should cancel. Killed channels hold full-scale codes, so any leak into the sums, the counters or the output word shows up directly. Irregular output back-pressure shows whether the words are held in place.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [2:0] {
    ST_LOAD, ST_P1, ST_P2, ST_P3, ST_CNT, ST_DEC, ST_OUT
  } cms_state_t;

  localparam logic [2:0] GSEL_W1   = 3'd0;
  localparam logic [2:0] GSEL_W2   = 3'd1;
  localparam logic [2:0] GSEL_W3   = 3'd2;
  localparam logic [2:0] GSEL_THR  = 3'd3;
  localparam logic [2:0] GSEL_MINU = 3'd4;
  localparam logic [2:0] GSEL_MAXR = 3'd5;
  localparam logic [2:0] GSEL_BYP  = 3'd6;
endpackage

// File: rtl/cms_cfg_regs.sv
module cms_cfg_regs
  import cms_pkg::*;
#(
  parameter int NCH      = 128,
  parameter int ADC_W    = 6,
  parameter int TH_W     = 6,
  parameter int TH_DEF   = 5,
  parameter int NCM_DEF  = 64,
  parameter int NREC_DEF = 31,
  localparam int CW      = $clog2(NCH),
  localparam int CNT_W   = CW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CW:0]      cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic [CW-1:0]    rd_idx,
  output logic [ADC_W-1:0] ped_o,
  output logic             kill_o,
  output logic [TH_W-1:0]  w1_o,
  output logic [TH_W-1:0]  w2_o,
  output logic [TH_W-1:0]  w3_o,
  output logic [TH_W-1:0]  thr_o,
  output logic [CNT_W-1:0] min_used_o,
  output logic [CNT_W-1:0] max_rec_o,
  output logic             bypass_o
);
  logic [ADC_W-1:0] ped_q [NCH];
  logic [NCH-1:0]   kill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) ped_q[i] <= '0;
      kill_q     <= '0;
      w1_o       <= TH_W'(TH_DEF);
      w2_o       <= TH_W'(TH_DEF);
      w3_o       <= TH_W'(TH_DEF);
      thr_o      <= TH_W'(TH_DEF);
      min_used_o <= CNT_W'(NCM_DEF);
      max_rec_o  <= CNT_W'(NREC_DEF);
      bypass_o   <= 1'b0;
    end else if (cfg_we) begin
      if (!cfg_addr[CW]) begin
        ped_q[cfg_addr[CW-1:0]]  <= cfg_wdata[ADC_W-1:0];
        kill_q[cfg_addr[CW-1:0]] <= cfg_wdata[7];
      end else begin
        case (cfg_addr[2:0])
          GSEL_W1:   w1_o       <= cfg_wdata[TH_W-1:0];
          GSEL_W2:   w2_o       <= cfg_wdata[TH_W-1:0];
          GSEL_W3:   w3_o       <= cfg_wdata[TH_W-1:0];
          GSEL_THR:  thr_o      <= cfg_wdata[TH_W-1:0];
          GSEL_MINU: min_used_o <= cfg_wdata[CNT_W-1:0];
          GSEL_MAXR: max_rec_o  <= cfg_wdata[CNT_W-1:0];
          GSEL_BYP:  bypass_o   <= cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  assign ped_o  = ped_q[rd_idx];
  assign kill_o = kill_q[rd_idx];
endmodule

// File: rtl/cms_sample_ram.sv
module cms_sample_ram #(
  parameter int NCH = 128,
  parameter int VW  = 7,
  localparam int CW = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [CW-1:0]        waddr,
  input  logic signed [VW-1:0] wdata,
  input  logic [CW-1:0]        raddr,
  output logic signed [VW-1:0] rdata
);
  logic signed [VW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cms_pass_engine.sv
module cms_pass_engine
  import cms_pkg::*;
#(
  parameter int NCH  = 128,
  parameter int VW   = 7,
  parameter int TH_W = 6,
  localparam int SHIFT = $clog2(NCH),
  localparam int CNT_W = SHIFT + 1,
  localparam int CMW   = VW + 1,
  localparam int XW    = VW + 3,
  localparam int SW    = VW + SHIFT + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  cms_state_t            st,
  input  logic                  last,
  input  logic signed [VW-1:0]  v,
  input  logic                  kill,
  input  logic [TH_W-1:0]       w1,
  input  logic [TH_W-1:0]       w2,
  input  logic [TH_W-1:0]       w3,
  input  logic [TH_W-1:0]       thr,
  output logic signed [CMW-1:0] cm_est,
  output logic [CNT_W-1:0]      n3,
  output logic [CNT_W-1:0]      nsig,
  output logic [CNT_W-1:0]      nrec
);
  localparam logic signed [SW-1:0] HALF = SW'(1 << (SHIFT - 1));

  logic signed [XW-1:0] vx, cmx, diff, adist, tw1, tw2, tw3, tthr;
  logic signed [SW-1:0] sum_q, sum_nx, addend;
  logic take, is_sig, is_rec;

  assign vx    = {{(XW-VW){v[VW-1]}}, v};
  assign cmx   = {{(XW-CMW){cm_est[CMW-1]}}, cm_est};
  assign tw1   = {{(XW-TH_W){1'b0}}, w1};
  assign tw2   = {{(XW-TH_W){1'b0}}, w2};
  assign tw3   = {{(XW-TH_W){1'b0}}, w3};
  assign tthr  = {{(XW-TH_W){1'b0}}, thr};
  assign diff  = vx - cmx;
  assign adist = diff[XW-1] ? -diff : diff;

  // Window selection for the three refinement passes
  always_comb begin
    case (st)
      ST_P1:   take = !kill && (vx > -tw1) && (vx < (tw1 <<< 1));
      ST_P2:   take = !kill && (adist < tw2);
      ST_P3:   take = !kill && (adist < tw3);
      default: take = 1'b0;
    endcase
  end

  assign is_sig = !kill && (vx > tthr);
  assign is_rec = !kill && (vx <= tthr) && (diff > tthr);
  assign addend = take ? {{(SW-VW){v[VW-1]}}, v} : '0;
  assign sum_nx = sum_q + addend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cm_est <= '0;
      n3     <= '0;
      nsig   <= '0;
      nrec   <= '0;
    end else begin
      case (st)
        ST_LOAD: begin
          sum_q <= '0;
          n3    <= '0;
          nsig  <= '0;
          nrec  <= '0;
        end
        ST_P1, ST_P2, ST_P3: begin
          sum_q <= last ? '0 : sum_nx;
          if (last) cm_est <= CMW'((sum_nx + HALF) >>> SHIFT);
          if (st == ST_P3 && take) n3 <= n3 + CNT_W'(1);
        end
        ST_CNT: begin
          if (is_sig) nsig <= nsig + CNT_W'(1);
          if (is_rec) nrec <= nrec + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (n3 <= CNT_W'(NCH)) && (nsig <= CNT_W'(NCH)) && (nrec <= CNT_W'(NCH))); // R7
  AST_KILLED_NOT_SUMMED: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && (st == ST_P1 || st == ST_P2 || st == ST_P3) && !last) |=> $stable(sum_q)); // R6
endmodule

// File: rtl/cms_suppressor.sv
module cms_suppressor
  import cms_pkg::*;
#(
  parameter int NCH      = 128,
  parameter int ADC_W    = 6,
  parameter int TH_W     = 6,
  parameter int TH_DEF   = 5,
  parameter int NCM_DEF  = 64,
  parameter int NREC_DEF = 31
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(NCH):0]    cfg_addr,
  input  logic [7:0]              cfg_wdata,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [ADC_W-1:0]        s_adc,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic [ADC_W+1:0]        m_data,
  output logic                    m_last,
  output logic [ADC_W+1:0]        cm_value,
  output logic [$clog2(NCH):0]    n3_count,
  output logic [$clog2(NCH):0]    nsig_count,
  output logic [$clog2(NCH):0]    nrec_count,
  output logic                    done
);
  localparam int CW    = $clog2(NCH);
  localparam int CNT_W = CW + 1;
  localparam int VW    = ADC_W + 1;
  localparam int OW    = VW + 1;

  cms_state_t st_q;
  logic [CW-1:0] idx_q;
  logic last_idx;

  logic [ADC_W-1:0] ped;
  logic kill;
  logic [TH_W-1:0] w1, w2, w3, thr;
  logic [CNT_W-1:0] min_used, max_rec;
  logic bypass;

  logic signed [VW-1:0] v_in, v_rd;
  logic signed [OW-1:0] v_wide, cm_eng, cm_q;
  logic [CNT_W-1:0] n3_eng, nsig_eng, nrec_eng;
  logic apply;

  assign last_idx = (idx_q == CW'(NCH - 1));

  cms_cfg_regs #(
    .NCH(NCH), .ADC_W(ADC_W), .TH_W(TH_W), .TH_DEF(TH_DEF),
    .NCM_DEF(NCM_DEF), .NREC_DEF(NREC_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_idx(idx_q), .ped_o(ped), .kill_o(kill),
    .w1_o(w1), .w2_o(w2), .w3_o(w3), .thr_o(thr),
    .min_used_o(min_used), .max_rec_o(max_rec), .bypass_o(bypass)
  );

  assign v_in = $signed({1'b0, s_adc}) - $signed({1'b0, ped});

  cms_sample_ram #(.NCH(NCH), .VW(VW)) u_ram (
    .clk(clk), .we(st_q == ST_LOAD && s_valid), .waddr(idx_q),
    .wdata(v_in), .raddr(idx_q), .rdata(v_rd)
  );

  cms_pass_engine #(.NCH(NCH), .VW(VW), .TH_W(TH_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .st(st_q), .last(last_idx), .v(v_rd),
    .kill(kill), .w1(w1), .w2(w2), .w3(w3), .thr(thr),
    .cm_est(cm_eng), .n3(n3_eng), .nsig(nsig_eng), .nrec(nrec_eng)
  );

  // Trust decision: enough quiet channels, not too many recovered hits
  assign apply = !bypass && (n3_eng >= min_used) && (nrec_eng <= max_rec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_LOAD;
      idx_q      <= '0;
      cm_q       <= '0;
      n3_count   <= '0;
      nsig_count <= '0;
      nrec_count <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_LOAD: if (s_valid) begin
          idx_q <= idx_q + CW'(1);
          if (last_idx) st_q <= ST_P1;
        end
        ST_P1, ST_P2, ST_P3, ST_CNT: begin
          idx_q <= idx_q + CW'(1);
          if (last_idx) st_q <= cms_state_t'(st_q + 3'd1);
        end
        ST_DEC: begin
          cm_q       <= apply ? cm_eng : '0;
          n3_count   <= n3_eng;
          nsig_count <= nsig_eng;
          nrec_count <= nrec_eng;
          done       <= 1'b1;
          st_q       <= ST_OUT;
        end
        ST_OUT: if (m_ready) begin
          idx_q <= idx_q + CW'(1);
          if (last_idx) st_q <= ST_LOAD;
        end
        default: st_q <= ST_LOAD;
      endcase
    end
  end

  assign v_wide   = {v_rd[VW-1], v_rd};
  assign s_ready  = (st_q == ST_LOAD);
  assign m_valid  = (st_q == ST_OUT);
  assign m_last   = m_valid && last_idx;
  assign m_data   = kill ? '0 : (v_wide - cm_q);
  assign cm_value = cm_q;

  AST_ONE_SIDE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && m_valid)); // R2
  AST_OUT_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last))); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> m_valid); // R11
  AST_VETO_FEW_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (n3_count < min_used)) |-> (cm_value == '0)); // R8
  AST_VETO_MANY_REC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (nrec_count > max_rec)) |-> (cm_value == '0)); // R8
  AST_BYPASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bypass) |-> (cm_value == '0)); // R9
endmodule

// File: tb/sim_cms_suppressor.sv
module sim_cms_suppressor;
  localparam int NCH = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [5:0] s_adc = '0;
  logic m_valid;
  logic m_ready = 1'b0;
  logic [7:0] m_data;
  logic m_last;
  logic [7:0] cm_value, n3_count, nsig_count, nrec_count;
  logic done;

  always #2 clk = ~clk;

  cms_suppressor u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_ready(s_ready),
    .s_adc(s_adc), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_last(m_last), .cm_value(cm_value), .n3_count(n3_count),
    .nsig_count(nsig_count), .nrec_count(nrec_count), .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;

  int adc_a [NCH];
  int ped_a [NCH];
  bit kill_a [NCH];
  int g_w1 = 5, g_w2 = 5, g_w3 = 5, g_thr = 5, g_minu = 64, g_maxr = 31;
  bit g_byp = 1'b0;
  int e_cm, e_n3, e_nsig, e_nrec;
  int e_out [NCH];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int fl128(input int s);
    return (s + 64) >>> 7;
  endfunction

  function automatic int iabs(input int x);
    return x < 0 ? -x : x;
  endfunction

  task automatic model();
    int v [NCH];
    int s, c1, c2, c3;
    for (int i = 0; i < NCH; i++) v[i] = adc_a[i] - ped_a[i];
    s = 0;
    for (int i = 0; i < NCH; i++)
      if (!kill_a[i] && v[i] > -g_w1 && v[i] < 2 * g_w1) s += v[i];
    c1 = fl128(s);
    s = 0;
    for (int i = 0; i < NCH; i++)
      if (!kill_a[i] && iabs(v[i] - c1) < g_w2) s += v[i];
    c2 = fl128(s);
    s = 0; e_n3 = 0;
    for (int i = 0; i < NCH; i++)
      if (!kill_a[i] && iabs(v[i] - c2) < g_w3) begin s += v[i]; e_n3++; end
    c3 = fl128(s);
    e_nsig = 0; e_nrec = 0;
    for (int i = 0; i < NCH; i++) begin
      if (!kill_a[i] && v[i] > g_thr) e_nsig++;
      if (!kill_a[i] && v[i] <= g_thr && v[i] - c3 > g_thr) e_nrec++;
    end
    e_cm = (g_byp || e_n3 < g_minu || e_nrec > g_maxr) ? 0 : c3;
    for (int i = 0; i < NCH; i++) e_out[i] = kill_a[i] ? 0 : v[i] - e_cm;
  endtask

  task automatic set_ch(input int i, input int v, input bit k);
    ped_a[i]  = 20 + (i * 3) % 12;
    adc_a[i]  = v + ped_a[i];
    kill_a[i] = k;
  endtask

  task automatic write_cfg(input bit globals);
    for (int i = 0; i < NCH; i++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 8'(i);
      cfg_wdata = {kill_a[i], 1'b0, 6'(ped_a[i])};
    end
    if (globals) begin
      for (int g = 0; g < 7; g++) begin
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h80 | 8'(g);
        case (g)
          0: cfg_wdata = 8'(g_w1);
          1: cfg_wdata = 8'(g_w2);
          2: cfg_wdata = 8'(g_w3);
          3: cfg_wdata = 8'(g_thr);
          4: cfg_wdata = 8'(g_minu);
          5: cfg_wdata = 8'(g_maxr);
          default: cfg_wdata = {7'd0, g_byp};
        endcase
      end
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_event(input string req, input bit globals, input bit bp);
    int j, cyc, guard;
    model();
    write_cfg(globals);
    for (int i = 0; i < NCH; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_adc = 6'(adc_a[i]);
    end
    @(negedge clk);
    s_valid = 1'b0;
    chk(s_ready == 1'b0, "R2", "s_ready after last sample", int'(s_ready), 0);
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R11", "done pulse", int'(done), 1);
    chk(m_valid == 1'b1, "R11", "first word valid with done", int'(m_valid), 1);
    chk(int'($signed(cm_value)) == e_cm, req, "cm_value", int'($signed(cm_value)), e_cm);
    chk(int'(n3_count) == e_n3, "R7", "n3_count", int'(n3_count), e_n3);
    chk(int'(nsig_count) == e_nsig, "R7", "nsig_count", int'(nsig_count), e_nsig);
    chk(int'(nrec_count) == e_nrec, "R7", "nrec_count", int'(nrec_count), e_nrec);
    j = 0; cyc = 0;
    while (j < NCH && cyc < 4000) begin
      m_ready = bp ? ((cyc % 3) != 1) : 1'b1;
      if (m_valid && m_ready) begin
        chk(int'($signed(m_data)) == e_out[j], "R10", $sformatf("word %0d", j),
            int'($signed(m_data)), e_out[j]);
        if (j == NCH - 1 || j == 0)
          chk(m_last == (j == NCH - 1), "R10", "m_last", int'(m_last), int'(j == NCH - 1));
        j++;
      end
      if (j < NCH) begin @(negedge clk); cyc++; end
    end
    @(negedge clk);
    m_ready = 1'b0;
    chk(m_valid == 1'b0 && s_ready == 1'b1, "R2", "return to collecting",
        int'(s_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(s_ready == 1'b1, "R1", "s_ready", int'(s_ready), 1);
    chk(m_valid == 1'b0, "R1", "m_valid", int'(m_valid), 0);
    chk(done == 1'b0, "R1", "done", int'(done), 0);
    chk(cm_value == 8'd0, "R1", "cm_value", int'(cm_value), 0);
    chk(n3_count == 8'd0 && nsig_count == 8'd0 && nrec_count == 8'd0,
        "R1", "counters", int'(n3_count), 0);

    // R3 reset defaults: globals never written
    for (int i = 0; i < NCH; i++) set_ch(i, 2 + ((i % 9 == 0) ? 30 : 0), 1'b0);
    run_event("R3", 1'b0, 1'b0);

    // R4 flat offset sweep across the lopsided pass-1 window
    for (int d = -8; d <= 10; d++) begin
      for (int i = 0; i < NCH; i++) set_ch(i, d, 1'b0);
      run_event("R4", 1'b1, 1'b0);
    end

    // R5 mixed hits and negative spikes
    for (int i = 0; i < NCH; i++)
      set_ch(i, 1 + ((i % 7 == 0) ? 25 : 0) - ((i % 11 == 0) ? 12 : 0), 1'b0);
    run_event("R5", 1'b1, 1'b0);

    // R6 killed channels hold full-scale codes
    for (int i = 0; i < NCH; i++) begin
      set_ch(i, -2, i % 4 == 0);
      if (i % 4 == 0) begin ped_a[i] = 0; adc_a[i] = 63; end
    end
    run_event("R6", 1'b1, 1'b0);
    chk(nsig_count == 8'd0, "R6", "killed not signals", int'(nsig_count), 0);

    // R11 negative estimate, sign bit set
    for (int i = 0; i < NCH; i++) set_ch(i, (i % 5 == 0) ? -4 : -3, 1'b0);
    run_event("R4", 1'b1, 1'b0);
    chk(cm_value[7] == 1'b1, "R11", "cm sign bit", int'(cm_value[7]), 1);

    // R8 too many recovered channels (40 > 31)
    for (int i = 0; i < NCH; i++) set_ch(i, (i % 16 < 5) ? 3 : -4, 1'b0);
    run_event("R8", 1'b1, 1'b0);

    // R7 same pattern with a relaxed limit: correction applied
    g_maxr = 63;
    run_event("R7", 1'b1, 1'b0);

    // R8 too few used channels (88 < 100)
    g_minu = 100;
    run_event("R8", 1'b1, 1'b0);
    g_minu = 64;

    // R9 bypass
    g_byp = 1'b1;
    run_event("R9", 1'b1, 1'b0);
    g_byp = 1'b0; g_maxr = 31;

    // R3 narrowed windows and threshold
    g_w1 = 2; g_w2 = 2; g_w3 = 2; g_thr = 3;
    for (int i = 0; i < NCH; i++) set_ch(i, (i % 5) - 2 + ((i % 13 == 0) ? 9 : 0), 1'b0);
    run_event("R3", 1'b1, 1'b0);
    g_w1 = 5; g_w2 = 5; g_w3 = 5; g_thr = 5;

    // R10 output back-pressure
    for (int i = 0; i < NCH; i++)
      set_ch(i, 3 + ((i % 7 == 0) ? 25 : 0), i % 10 == 3);
    run_event("R10", 1'b1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule